// File: doc/BRIEF.md
# Trigger Request Delay Generator

This block turns a set of trigger sources into one level-1 request and holds it back by a programmable number of bunch-crossing strobes before releasing it. The sources are a core track finder, which marks a found track with a nonzero mode code, and seven single-source hit bits: five from chamber groups and two from barrel groups. An enable mask selects which single sources can raise the request. A separate core enable controls both whether the core can raise it and whether the core's mode code is forwarded.

Each request travels together with a mode code. A core track forwards its own mode. A request raised only by single sources carries the fixed pseudo-track code 0xB. The delay is built as a circular buffer that first fills up to the programmed depth and then writes and reads once per strobe. Its live occupancy is shown beside the applied delay in a 16-bit readback word. Writing a new delay value empties the buffer and starts the fill again.

Recommended driver reset values are a delay of 0, all single-source enables cleared, and the core enable set.

Top module: `trq_top`

## Requirements
- R1: After reset with a delay setting of 0, `req_out` is 0, `trk_mode` is 0 and `cfg_word` is 0x0000.
- R2: The request equals (core_en AND core_mode != 0) OR any bit of (cham_hit AND cham_en) OR any bit of (barrel_hit AND barrel_en). Hits whose enable bit is 0 have no effect, and a nonzero core mode has no effect while core_en is 0.
- R3: The mode sent with a request is core_mode whenever the core raises it, even if single sources are also hit. It is 0xB when only single sources raise the request, and 0 when there is no request. `trk_mode` is nonzero exactly when `req_out` is 1.
- R4: With a delay of 0, `req_out` and `trk_mode` show the inputs sampled at the most recent strobed clock edge (one register stage).
- R5: With a delay D from 1 to 127, the output after the k-th strobe since the last flush shows the inputs sampled at strobe k-D. For the first D strobes (the fill) the output is 0.
- R6: `cfg_word[6:0]` is the applied delay and `cfg_word[14:8]` is the buffer occupancy. After k strobes since the last flush, the occupancy is min(k, D), and it never exceeds the delay. Bits 15 and 7 read 0.
- R7: When `delay_set` differs from the applied delay, the next clock edge flushes the buffer. After that edge, the occupancy and the outputs are 0, the new delay is applied, and any strobe at that edge is dropped.
- R8: A clock edge without `bx_strobe` and without a flush changes neither the outputs nor the occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_strobe | input | 1 | One-clock strobe per bunch crossing; advances the pipeline |
| core_mode | input | 4 | Core track mode; nonzero marks a found track |
| cham_hit | input | 5 | Single-source hits from the chamber groups |
| barrel_hit | input | 2 | Single-source hits from the barrel groups |
| core_en | input | 1 | Core enable for the request and mode forwarding |
| cham_en | input | 5 | Per-source enables for the chamber hits |
| barrel_en | input | 2 | Per-source enables for the barrel hits |
| delay_set | input | 7 | Requested delay in strobes (0 to 127) |
| req_out | output | 1 | Delayed level-1 request |
| trk_mode | output | 4 | Delayed mode code sent with the request |
| cfg_word | output | 16 | Readback: {0, occupancy[6:0], 0, delay[6:0]} |

## Verification
The bench attacks the precedence between a core track and a simultaneous single-source hit. A design that got it backwards would emit 0xB where the core mode belongs. It also feeds disabled hits and a disabled core carrying a nonzero mode; a leaky mask would raise phantom requests. Delays of 0, 2, 4 and 127 are checked strobe by strobe, with stalls inserted. An off-by-one in the fill, a pointer that advances without a strobe, or a counter that wraps at the maximum depth would each show up as a misplaced pulse or a wrong occupancy. A delay change in the middle of a run checks that stale entries are flushed rather than leaking out after the new fill.

// File: rtl/trq_pkg.sv
package trq_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] PSEUDO_MODE = 4'hB;

  // Mode carried with the request: the core wins over single sources.
  function automatic logic [MODE_W-1:0] pick_mode(input logic core_hit,
                                                  input logic src_hit,
                                                  input logic [MODE_W-1:0] cmode);
    if (core_hit) return cmode;
    else if (src_hit) return PSEUDO_MODE;
    else return '0;
  endfunction

  // Occupancy after one more strobe during fill: saturates at the delay.
  function automatic int unsigned fill_next(input int unsigned cnt,
                                            input int unsigned dly);
    return (cnt < dly) ? cnt + 1 : dly;
  endfunction
endpackage

// File: rtl/trq_merge.sv
module trq_merge
  import trq_pkg::*;
#(
  parameter int N_CHAM   = 5,
  parameter int N_BARREL = 2
) (
  input  logic [MODE_W-1:0]   core_mode,
  input  logic                core_en,
  input  logic [N_CHAM-1:0]   cham_hit,
  input  logic [N_CHAM-1:0]   cham_en,
  input  logic [N_BARREL-1:0] barrel_hit,
  input  logic [N_BARREL-1:0] barrel_en,
  output logic                core_hit,
  output logic                src_hit,
  output logic                req,
  output logic [MODE_W-1:0]   mode
);
  localparam int N_SRC = N_CHAM + N_BARREL;

  logic [N_SRC-1:0] src_vec;
  logic [N_SRC-1:0] en_vec;
  logic [N_SRC-1:0] gated;

  assign src_vec = {barrel_hit, cham_hit};
  assign en_vec  = {barrel_en, cham_en};

  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    assign gated[g] = src_vec[g] & en_vec[g];
  end

  assign core_hit = core_en && (core_mode != '0);
  assign src_hit  = |gated;
  assign req      = core_hit | src_hit;
  assign mode     = pick_mode(core_hit, src_hit, core_mode);
endmodule

// File: rtl/trq_delay_line.sv
module trq_delay_line #(
  parameter int DLY_W = 7,
  parameter int ENT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [DLY_W-1:0] delay_set,
  input  logic [ENT_W-1:0] in_ent,
  output logic [ENT_W-1:0] out_ent,
  output logic [DLY_W-1:0] count,
  output logic [DLY_W-1:0] delay_q,
  output logic             flush,
  output logic             push,
  output logic             pop
);
  localparam int DEPTH = 1 << DLY_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [DLY_W-1:0] wr_ptr;
  logic [DLY_W-1:0] rd_ptr;
  logic             bypass;
  logic [DLY_W-1:0] count_nxt;

  assign flush     = (delay_set != delay_q);
  assign bypass    = strobe && !flush && (delay_q == '0);
  assign push      = strobe && !flush && (delay_q != '0);
  assign pop       = push && (count == delay_q);
  assign count_nxt = DLY_W'(trq_pkg::fill_next(int'(count), int'(delay_q)));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delay_q <= '0;
      count   <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      out_ent <= '0;
    end else if (flush) begin
      delay_q <= delay_set;
      count   <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      out_ent <= '0;
    end else if (bypass) begin
      out_ent <= in_ent;
    end else if (push) begin
      wr_ptr <= wr_ptr + 1'b1;
      count  <= count_nxt;
      if (pop) begin
        rd_ptr  <= rd_ptr + 1'b1;
        out_ent <= mem[rd_ptr];
      end else begin
        out_ent <= '0;
      end
    end
  end
endmodule

// File: rtl/trq_top.sv
module trq_top
  import trq_pkg::*;
#(
  parameter int N_CHAM   = 5,
  parameter int N_BARREL = 2,
  parameter int DLY_W    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bx_strobe,
  input  logic [MODE_W-1:0]     core_mode,
  input  logic [N_CHAM-1:0]     cham_hit,
  input  logic [N_BARREL-1:0]   barrel_hit,
  input  logic                  core_en,
  input  logic [N_CHAM-1:0]     cham_en,
  input  logic [N_BARREL-1:0]   barrel_en,
  input  logic [DLY_W-1:0]      delay_set,
  output logic                  req_out,
  output logic [MODE_W-1:0]     trk_mode,
  output logic [2*DLY_W+1:0]    cfg_word
);
  localparam int ENT_W = MODE_W + 1;

  logic              mg_core_hit;
  logic              mg_src_hit;
  logic              mg_req;
  logic [MODE_W-1:0] mg_mode;
  logic [ENT_W-1:0]  dl_out;
  logic [DLY_W-1:0]  dl_count;
  logic [DLY_W-1:0]  dl_delay;
  logic              dl_flush;
  logic              dl_push;
  logic              dl_pop;

  trq_merge #(.N_CHAM(N_CHAM), .N_BARREL(N_BARREL)) u_merge (
    .core_mode (core_mode),
    .core_en   (core_en),
    .cham_hit  (cham_hit),
    .cham_en   (cham_en),
    .barrel_hit(barrel_hit),
    .barrel_en (barrel_en),
    .core_hit  (mg_core_hit),
    .src_hit   (mg_src_hit),
    .req       (mg_req),
    .mode      (mg_mode)
  );

  trq_delay_line #(.DLY_W(DLY_W), .ENT_W(ENT_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (bx_strobe),
    .delay_set(delay_set),
    .in_ent   ({mg_req, mg_mode}),
    .out_ent  (dl_out),
    .count    (dl_count),
    .delay_q  (dl_delay),
    .flush    (dl_flush),
    .push     (dl_push),
    .pop      (dl_pop)
  );

  assign req_out  = dl_out[ENT_W-1];
  assign trk_mode = dl_out[MODE_W-1:0];
  assign cfg_word = {1'b0, dl_count, 1'b0, dl_delay};
endmodule

// File: rtl/trq_chk.sv
module trq_chk #(
  parameter int DLY_W  = 7,
  parameter int MODE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bx_strobe,
  input logic               flush,
  input logic               req_out,
  input logic [MODE_W-1:0]  trk_mode,
  input logic [2*DLY_W+1:0] cfg_word
);
  logic [DLY_W-1:0] occ;
  logic [DLY_W-1:0] dly;
  assign occ = cfg_word[2*DLY_W:DLY_W+1];
  assign dly = cfg_word[DLY_W-1:0];

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[2*DLY_W+1] && !cfg_word[DLY_W]);

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= dly);

  // R3
  mode_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_out == (trk_mode != '0));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0) && !req_out);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bx_strobe && !flush) |=> $stable(req_out) && $stable(trk_mode) && $stable(occ));

  // R5
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_strobe && !flush && (occ < dly)) |=> !req_out);
endmodule

bind trq_top trq_chk #(.DLY_W(DLY_W), .MODE_W(trq_pkg::MODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bx_strobe(bx_strobe),
  .flush    (dl_flush),
  .req_out  (req_out),
  .trk_mode (trk_mode),
  .cfg_word (cfg_word)
);

// File: tb/trq_top_test.sv
module trq_top_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bx_strobe = 0;
  logic [3:0] core_mode = 0;
  logic [4:0] cham_hit = 0;
  logic [1:0] barrel_hit = 0;
  logic       core_en = 1;
  logic [4:0] cham_en = 0;
  logic [1:0] barrel_en = 0;
  logic [6:0] delay_set = 0;
  logic       req_out;
  logic [3:0] trk_mode;
  logic [15:0] cfg_word;

  int checks = 0;
  int failures = 0;
  logic [4:0] hist [256];

  always #2 clk = ~clk;

  trq_top uut (.*);

  // fields: cham_en[23:19] barrel_en[18:17] core_en[16] cham_hit[15:11]
  //         barrel_hit[10:9] core_mode[8:5] exp_req[4] exp_mode[3:0]
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {5'b00000, 2'b00, 1'b1, 5'b00000, 2'b00, 4'h0, 1'b0, 4'h0},
    {5'b00000, 2'b00, 1'b1, 5'b00000, 2'b00, 4'h5, 1'b1, 4'h5},
    {5'b00000, 2'b00, 1'b0, 5'b00000, 2'b00, 4'h5, 1'b0, 4'h0},
    {5'b00100, 2'b00, 1'b0, 5'b00100, 2'b00, 4'h0, 1'b1, 4'hB},
    {5'b00100, 2'b00, 1'b0, 5'b11011, 2'b00, 4'h0, 1'b0, 4'h0},
    {5'b00000, 2'b10, 1'b0, 5'b00000, 2'b10, 4'h0, 1'b1, 4'hB},
    {5'b00000, 2'b01, 1'b0, 5'b00000, 2'b10, 4'h0, 1'b0, 4'h0},
    {5'b11111, 2'b00, 1'b1, 5'b10000, 2'b00, 4'h3, 1'b1, 4'h3},
    {5'b00001, 2'b00, 1'b0, 5'b00001, 2'b00, 4'hF, 1'b1, 4'hB},
    {5'b00000, 2'b11, 1'b1, 5'b00000, 2'b01, 4'h0, 1'b1, 4'hB},
    {5'b00000, 2'b00, 1'b1, 5'b00000, 2'b00, 4'hF, 1'b1, 4'hF}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s);
    @(negedge clk) bx_strobe = s;
    @(posedge clk);
    #1;
    bx_strobe = 0;
  endtask

  function automatic logic [4:0] ref_ent();
    if (core_en && core_mode != 0) return {1'b1, core_mode};
    if (|(cham_hit & cham_en) || |(barrel_hit & barrel_en)) return 5'h1B;
    return 5'h00;
  endfunction

  // Strobe-by-strobe run at delay d starting right after a flush.
  task automatic run_delay(input int d, input int n, input int stall_at);
    logic [4:0] expv;
    int ec;
    for (int i = 0; i < n; i++) begin
      core_en = 1; cham_en = 0; barrel_en = 0; cham_hit = 0; barrel_hit = 0;
      core_mode = (i % 2 == 1) ? 4'(i + 1) : 4'h0;
      if (i % 4 == 2) begin cham_en = 5'b00010; cham_hit = 5'b00010; end
      hist[i] = ref_ent();
      step(1);
      expv = (i >= d) ? hist[i - d] : 5'h00;
      ec = (i + 1 < d) ? i + 1 : d;
      // R4 R5
      check({req_out, trk_mode} == expv, (d == 0) ? "R4 output" : "R5 output",
            {req_out, trk_mode}, expv);
      // R6
      check(cfg_word[14:8] == ec && cfg_word[6:0] == d && !cfg_word[15] && !cfg_word[7],
            "R6 readback", cfg_word, {ec[6:0], 1'b0, 7'(d)});
      if (i == stall_at) begin
        core_mode = 4'hE; cham_en = '1; cham_hit = '1;
        for (int k = 0; k < 3; k++) begin
          step(0);
          // R8
          check({req_out, trk_mode} == expv && cfg_word[14:8] == ec, "R8 stall",
                {req_out, trk_mode, cfg_word[14:8]}, {expv, 7'(ec)});
        end
      end
    end
  endtask

  task automatic set_delay(input int d);
    delay_set = 7'(d);
    step(0);
    // R7
    check(cfg_word == {9'd0, 7'(d)} && !req_out && trk_mode == 0, "R7 flush",
          cfg_word, {9'd0, 7'(d)});
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(!req_out && trk_mode == 0 && cfg_word == 0, "R1 reset",
          {req_out, trk_mode, cfg_word}, 0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    check(!req_out && cfg_word == 0, "R1 after release", cfg_word, 0);

    // Vector table at delay 0: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      cham_en    = VEC[v][23:19];
      barrel_en  = VEC[v][18:17];
      core_en    = VEC[v][16];
      cham_hit   = VEC[v][15:11];
      barrel_hit = VEC[v][10:9];
      core_mode  = VEC[v][8:5];
      step(1);
      check(req_out == VEC[v][4], "R2 request", req_out, VEC[v][4]);
      check(trk_mode == VEC[v][3:0], "R3 mode", trk_mode, VEC[v][3:0]);
    end

    run_delay(0, 6, 2);
    set_delay(4);
    run_delay(4, 14, 6);
    set_delay(2);
    run_delay(2, 8, 1);
    set_delay(127);
    run_delay(127, 135, 126);
    set_delay(0);
    run_delay(0, 3, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule